// File: doc/BRIEF.md
# Indirect-Access Ethernet Controller Register Bank

This block is the software-visible control and status register bank of an Ethernet controller. Software reaches it through two 16-bit ports only. A pointer port (byte offset 2) picks one of four registers, and a data port (byte offset 0) reads or writes whichever register was picked last. The pointer keeps its value, so software can select the control register once and then poll it over and over.

The control register holds the commands (halt, start, initialize, transmit demand), the interrupt enable, the receiver and transmitter run state, seven event flags and two summary bits. The MAC datapath reports events on single-cycle pulse inputs. The bank latches these events, combines them into one interrupt output, and emits one-cycle pulses for transmit demand and for the start of initialization. The other three registers hold a 24-bit initialization-block address and three bus-mode bits. Software may change these only while the controller is halted.

The datapath, the DMA engine and the reading of the initialization block are outside this block. Completion or failure of initialization comes back as an input pulse.

Top module: `enet_csr_bank`

## Requirements
- R1: Writing the pointer port (acc_ptr_sel=1) loads the register number from data bits 1:0. Reading the pointer port returns that number in bits 1:0, with zeros above. Data-port accesses (acc_ptr_sel=0) go to register 0 = control, 1 = address low, 2 = address high, 3 = bus mode.
- R2: After reset the pointer is 0, the control register reads 0x0004 (halted), registers 1 to 3 read 0, and irq, rx_on, tx_on, tx_demand and init_start are 0.
- R3: Control bits 14 to 8 are event flags. From bit 14 down they are babble, collision, missed frame, memory error, receive done, transmit done and init done. A pulse on an event input sets its flag. Writing 1 to a flag clears it, and writing 0 leaves it unchanged. When an event arrives in the same cycle as a clearing write, the flag stays set.
- R4: Bit 15 is read-only and reads as the OR of bits 14 to 11. Writes to bit 15 have no effect.
- R5: Bit 7 is read-only and reads as the OR of bit 15, bit 10, bit 9 and bit 8. irq is high exactly when bit 7 and bit 6 (interrupt enable) are both 1.
- R6: Writing 1 to bit 2 halts the controller. Bit 2 reads 1, and bits 14 to 8, bit 6, bit 5 (receiver on) and bit 4 (transmitter on) are cleared. While halted, event pulses are ignored. A halt in the same write as start or init takes precedence.
- R7: Writing 1 to bit 1 (start) clears the halt and sets bits 5 and 4. In the same write, bit 6 takes the written value.
- R8: Writing 1 to bit 0 (init) clears the halt and gives a one-cycle init_start pulse. An init-done pulse sets bit 8. An init-fail pulse sets bit 11, which makes bit 15 read 1.
- R9: Writing 1 to bit 3 while the transmitter is on gives a one-cycle tx_demand pulse. When the transmitter is off, the write is ignored.
- R10: Bits 3, 1 and 0 clear themselves. After an accepted write each reads 1 for exactly one cycle, then reads 0.
- R11: Register 1 holds address bits 15:0. Register 2 bits 7:0 hold address bits 23:16, and its bits 15:8 read 0. Register 3 bits 2:0 hold the bus mode (byte swap, address-latch control, byte control), and its upper bits read 0. ib_addr and bus_mode show these values.
- R12: Writes to registers 1 to 3 take effect only while the controller is halted. At other times they leave the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ptr_sel | input | 1 | 1 = pointer port (offset 2), 0 = data port (offset 0) |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data of the port addressed by acc_ptr_sel |
| ev_babble | input | 1 | Transmit babble event pulse |
| ev_collision | input | 1 | Collision/heartbeat error event pulse |
| ev_missed | input | 1 | Missed frame event pulse |
| ev_mem_err | input | 1 | Memory error event pulse |
| ev_rx_done | input | 1 | Receive complete event pulse |
| ev_tx_done | input | 1 | Transmit complete event pulse |
| ev_init_done | input | 1 | Initialization finished pulse |
| ev_init_fail | input | 1 | Initialization failure pulse |
| irq | output | 1 | Combined interrupt request |
| rx_on | output | 1 | Receiver running |
| tx_on | output | 1 | Transmitter running |
| stopped | output | 1 | Controller halted |
| tx_demand | output | 1 | One-cycle transmit demand |
| init_start | output | 1 | One-cycle initialization request |
| ib_addr | output | 24 | Initialization-block address |
| bus_mode | output | 3 | Bus-mode bits |

## Verification
Some properties are checked by assertions on every cycle. The interrupt output always agrees with the summary and enable bits. A halted controller never shows a running side, an enabled interrupt or a pending flag. The demand and init pulses never last past one cycle, and a demand pulse never appears while the transmitter is off. The configuration outputs do not move while the controller runs. Other behaviour only the bench scenarios can show: the pointer indirection, write-one-to-clear on the flags, an event beating a clear in the same cycle, a halt beating a start, locked configuration writes being dropped, and the init-fail path reaching the error summary.

// File: rtl/enet_csr_pkg.sv
package enet_csr_pkg;

  localparam int CSR_W    = 16;
  localparam int NUM_REGS = 4;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int IBA_W    = 24;
  localparam int MODE_W   = 3;
  localparam int FLAG_N   = 7;

  // control register bit positions (software decodes these)
  localparam int B_ERRSUM  = 15;
  localparam int B_FLAG_HI = 14;
  localparam int B_FLAG_LO = 8;
  localparam int B_INTSUM  = 7;
  localparam int B_IEN     = 6;
  localparam int B_RXRUN   = 5;
  localparam int B_TXRUN   = 4;
  localparam int B_TXDEM   = 3;
  localparam int B_HALT    = 2;
  localparam int B_GO      = 1;
  localparam int B_INIT    = 0;

  // flag index (bit = B_FLAG_LO + index); indices at or above ERR_BASE feed the error summary
  localparam int F_INITDONE = 0;
  localparam int F_TXDONE   = 1;
  localparam int F_RXDONE   = 2;
  localparam int F_MEMERR   = 3;
  localparam int ERR_BASE   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_IBLO  = 2'd1,
    SEL_IBHI  = 2'd2,
    SEL_BMODE = 2'd3
  } csr_sel_e;

endpackage

// File: rtl/csr_port_decode.sv
module csr_port_decode #(
  parameter int DW    = 16,
  parameter int NR    = 4,
  localparam int SW   = $clog2(NR)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic           acc_write,
  input  logic           acc_ptr_sel,
  input  logic [SW-1:0]  ptr_wdata,
  input  logic [NR*DW-1:0] reg_rd,
  output logic [NR-1:0]  wr_en,
  output logic [SW-1:0]  sel,
  output logic [DW-1:0]  rdata
);

  logic [SW-1:0] sel_q, sel_d;
  logic          ptr_we;
  logic          data_we;

  assign ptr_we  = acc_valid & acc_write & acc_ptr_sel;
  assign data_we = acc_valid & acc_write & ~acc_ptr_sel;

  always_comb begin
    sel_d = sel_q;
    if (ptr_we) sel_d = ptr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (ptr_we) sel_q <= sel_d;
  end

  for (genvar g = 0; g < NR; g++) begin : g_we
    assign wr_en[g] = data_we & (sel_q == SW'(g));
  end

  always_comb begin
    if (acc_ptr_sel) rdata = {{(DW-SW){1'b0}}, sel_q};
    else             rdata = reg_rd[sel_q*DW +: DW];
  end

  assign sel = sel_q;

endmodule

// File: rtl/csr_ctrl_reg.sv
module csr_ctrl_reg
  import enet_csr_pkg::*;
#(
  parameter int NF = FLAG_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [NF-1:0]  wr_flag_clr,
  input  logic           wr_ien,
  input  logic           wr_txdem,
  input  logic           wr_halt,
  input  logic           wr_go,
  input  logic           wr_init,
  input  logic [NF-1:0]  evt_set,
  output logic [CSR_W-1:0] ctl_word,
  output logic           halted,
  output logic           rx_run,
  output logic           tx_run,
  output logic           irq,
  output logic           txdem_pulse,
  output logic           init_pulse
);

  logic [NF-1:0] flags_q, flags_d;
  logic ien_q, ien_d;
  logic rxr_q, rxr_d;
  logic txr_q, txr_d;
  logic halt_q, halt_d;
  logic tdm_q, tdm_d;
  logic go_q, go_d;
  logic ini_q, ini_d;

  logic do_halt, do_go, do_init, do_tdm;
  logic err_sum, int_sum;

  assign do_halt = wr_en & wr_halt;
  assign do_go   = wr_en & wr_go   & ~wr_halt;
  assign do_init = wr_en & wr_init & ~wr_halt;
  assign do_tdm  = wr_en & wr_txdem & ~wr_halt & txr_q;

  always_comb begin
    flags_d = flags_q;
    if (halt_q || do_halt) begin
      flags_d = '0;
    end else begin
      if (wr_en) flags_d = flags_d & ~wr_flag_clr;
      flags_d = flags_d | evt_set;
    end

    ien_d = ien_q;
    if (do_halt)    ien_d = 1'b0;
    else if (wr_en) ien_d = wr_ien & (~halt_q | do_go | do_init);

    halt_d = halt_q;
    if (do_halt)               halt_d = 1'b1;
    else if (do_go || do_init) halt_d = 1'b0;

    rxr_d = rxr_q;
    txr_d = txr_q;
    if (do_halt) begin
      rxr_d = 1'b0;
      txr_d = 1'b0;
    end else if (do_go) begin
      rxr_d = 1'b1;
      txr_d = 1'b1;
    end

    tdm_d = do_tdm;
    go_d  = do_go;
    ini_d = do_init;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ien_q   <= 1'b0;
      rxr_q   <= 1'b0;
      txr_q   <= 1'b0;
      halt_q  <= 1'b1;
      tdm_q   <= 1'b0;
      go_q    <= 1'b0;
      ini_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      ien_q   <= ien_d;
      rxr_q   <= rxr_d;
      txr_q   <= txr_d;
      halt_q  <= halt_d;
      tdm_q   <= tdm_d;
      go_q    <= go_d;
      ini_q   <= ini_d;
    end
  end

  assign err_sum = |flags_q[NF-1:ERR_BASE];
  assign int_sum = err_sum | (|flags_q[ERR_BASE-1:0]);

  always_comb begin
    ctl_word = '0;
    ctl_word[B_ERRSUM]            = err_sum;
    ctl_word[B_FLAG_HI:B_FLAG_LO] = flags_q;
    ctl_word[B_INTSUM]            = int_sum;
    ctl_word[B_IEN]               = ien_q;
    ctl_word[B_RXRUN]             = rxr_q;
    ctl_word[B_TXRUN]             = txr_q;
    ctl_word[B_TXDEM]             = tdm_q;
    ctl_word[B_HALT]              = halt_q;
    ctl_word[B_GO]                = go_q;
    ctl_word[B_INIT]              = ini_q;
  end

  assign halted      = halt_q;
  assign rx_run      = rxr_q;
  assign tx_run      = txr_q;
  assign irq         = int_sum & ien_q;
  assign txdem_pulse = tdm_q;
  assign init_pulse  = ini_q;

endmodule

// File: rtl/csr_cfg_regs.sv
module csr_cfg_regs #(
  parameter int DW = 16,
  parameter int AW = 24,
  parameter int MW = 3,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unlocked,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_mode,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lo_word,
  output logic [DW-1:0] hi_word,
  output logic [DW-1:0] mode_word,
  output logic [AW-1:0] ib_addr,
  output logic [MW-1:0] bus_mode
);

  logic [DW-1:0] lo_q, lo_d;
  logic [HW-1:0] hi_q, hi_d;
  logic [MW-1:0] md_q, md_d;
  logic en_lo, en_hi, en_md;

  assign en_lo = unlocked & wr_lo;
  assign en_hi = unlocked & wr_hi;
  assign en_md = unlocked & wr_mode;

  always_comb begin
    lo_d = wdata;
    hi_d = wdata[HW-1:0];
    md_d = wdata[MW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      md_q <= '0;
    end else begin
      if (en_lo) lo_q <= lo_d;
      if (en_hi) hi_q <= hi_d;
      if (en_md) md_q <= md_d;
    end
  end

  assign lo_word   = lo_q;
  assign hi_word   = {{(DW-HW){1'b0}}, hi_q};
  assign mode_word = {{(DW-MW){1'b0}}, md_q};
  assign ib_addr   = {hi_q, lo_q};
  assign bus_mode  = md_q;

endmodule

// File: rtl/enet_csr_bank.sv
module enet_csr_bank
  import enet_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_ptr_sel,
  input  logic [CSR_W-1:0]  acc_wdata,
  output logic [CSR_W-1:0]  acc_rdata,
  input  logic              ev_babble,
  input  logic              ev_collision,
  input  logic              ev_missed,
  input  logic              ev_mem_err,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_init_done,
  input  logic              ev_init_fail,
  output logic              irq,
  output logic              rx_on,
  output logic              tx_on,
  output logic              stopped,
  output logic              tx_demand,
  output logic              init_start,
  output logic [IBA_W-1:0]  ib_addr,
  output logic [MODE_W-1:0] bus_mode
);

  logic [NUM_REGS-1:0]       wr_en;
  logic [SEL_W-1:0]          sel;
  logic [NUM_REGS*CSR_W-1:0] reg_rd;
  logic [CSR_W-1:0]          ctl_word;
  logic [CSR_W-1:0]          lo_word, hi_word, mode_word;
  logic [FLAG_N-1:0]         evt_set;

  assign evt_set = {ev_babble, ev_collision, ev_missed, ev_mem_err | ev_init_fail,
                    ev_rx_done, ev_tx_done, ev_init_done};

  assign reg_rd = {mode_word, hi_word, lo_word, ctl_word};

  csr_port_decode #(.DW(CSR_W), .NR(NUM_REGS)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_ptr_sel (acc_ptr_sel),
    .ptr_wdata   (acc_wdata[SEL_W-1:0]),
    .reg_rd      (reg_rd),
    .wr_en       (wr_en),
    .sel         (sel),
    .rdata       (acc_rdata)
  );

  csr_ctrl_reg #(.NF(FLAG_N)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en[SEL_CTRL]),
    .wr_flag_clr (acc_wdata[B_FLAG_HI:B_FLAG_LO]),
    .wr_ien      (acc_wdata[B_IEN]),
    .wr_txdem    (acc_wdata[B_TXDEM]),
    .wr_halt     (acc_wdata[B_HALT]),
    .wr_go       (acc_wdata[B_GO]),
    .wr_init     (acc_wdata[B_INIT]),
    .evt_set     (evt_set),
    .ctl_word    (ctl_word),
    .halted      (stopped),
    .rx_run      (rx_on),
    .tx_run      (tx_on),
    .irq         (irq),
    .txdem_pulse (tx_demand),
    .init_pulse  (init_start)
  );

  csr_cfg_regs #(.DW(CSR_W), .AW(IBA_W), .MW(MODE_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .unlocked  (stopped),
    .wr_lo     (wr_en[SEL_IBLO]),
    .wr_hi     (wr_en[SEL_IBHI]),
    .wr_mode   (wr_en[SEL_BMODE]),
    .wdata     (acc_wdata),
    .lo_word   (lo_word),
    .hi_word   (hi_word),
    .mode_word (mode_word),
    .ib_addr   (ib_addr),
    .bus_mode  (bus_mode)
  );

endmodule

// File: rtl/enet_csr_bank_chk.sv
module enet_csr_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        stopped,
  input logic        rx_on,
  input logic        tx_on,
  input logic        tx_demand,
  input logic        init_start,
  input logic [15:0] ctl_word,
  input logic [23:0] ib_addr,
  input logic [2:0]  bus_mode
);

  a_r5_irq_gating: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ctl_word[7] & ctl_word[6]));

  a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!rx_on && !tx_on && !ctl_word[6] && ctl_word[14:8] == 7'd0 && !irq));

  a_r9_demand_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_demand |=> !tx_demand);

  a_r9_demand_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_demand |-> tx_on);

  a_r8_init_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> !init_start);

  a_r12_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |=> ($stable(ib_addr) && $stable(bus_mode)));

endmodule

bind enet_csr_bank enet_csr_bank_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .stopped    (stopped),
  .rx_on      (rx_on),
  .tx_on      (tx_on),
  .tx_demand  (tx_demand),
  .init_start (init_start),
  .ctl_word   (ctl_word),
  .ib_addr    (ib_addr),
  .bus_mode   (bus_mode)
);

// File: tb/enet_csr_bank_tb_top.sv
module enet_csr_bank_tb_top;

  logic        clk;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_ptr_sel;
  logic [15:0] acc_wdata, acc_rdata;
  logic [7:0]  ev;
  logic        irq, rx_on, tx_on, stopped, tx_demand, init_start;
  logic [23:0] ib_addr;
  logic [2:0]  bus_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // ev index: 0 init_done 1 tx_done 2 rx_done 3 mem_err 4 missed 5 collision 6 babble 7 init_fail
  enet_csr_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_ptr_sel(acc_ptr_sel),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ev_babble(ev[6]), .ev_collision(ev[5]), .ev_missed(ev[4]), .ev_mem_err(ev[3]),
    .ev_rx_done(ev[2]), .ev_tx_done(ev[1]), .ev_init_done(ev[0]), .ev_init_fail(ev[7]),
    .irq(irq), .rx_on(rx_on), .tx_on(tx_on), .stopped(stopped),
    .tx_demand(tx_demand), .init_start(init_start),
    .ib_addr(ib_addr), .bus_mode(bus_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {ptr_port, write data, expected data-port readback afterwards}
  localparam logic [32:0] VEC [11] = '{
    {1'b1, 16'h0001, 16'h0000},  // R1 select address low
    {1'b0, 16'h1234, 16'h1234},  // R11 low address while halted
    {1'b1, 16'h0002, 16'h0000},  // R1
    {1'b0, 16'hFFAB, 16'h00AB},  // R11 high byte only
    {1'b1, 16'h0003, 16'h0000},  // R1
    {1'b0, 16'hFFFF, 16'h0007},  // R11 bus mode 3 bits
    {1'b1, 16'h0000, 16'h0004},  // R1 back to control, halted
    {1'b0, 16'h0042, 16'h0072},  // R7 R10 start with enable
    {1'b1, 16'h0001, 16'h1234},  // R1
    {1'b0, 16'h5555, 16'h1234},  // R12 locked while running
    {1'b1, 16'h0000, 16'h0070}   // R10 start bit cleared
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_ptr_sel = p; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_ptr_sel = 1'b0; acc_wdata = '0;
    #1;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev = '0;
    #1;
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_ptr_sel = 0; acc_wdata = '0; ev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R2 reset state
    chk("R2 ctrl", acc_rdata, 16'h0004);
    acc_ptr_sel = 1'b1; #1;
    chk("R2 pointer", acc_rdata, 16'h0000);
    acc_ptr_sel = 1'b0; #1;
    chk("R2 outputs", {10'd0, irq, rx_on, tx_on, tx_demand, init_start, stopped}, 16'h0001);
    chk("R2 ib_addr", ib_addr[15:0], 16'h0000);

    for (int i = 0; i < 11; i++) begin
      wr(VEC[i][32], VEC[i][31:16]);
      chk($sformatf("vec%0d R1/R7/R10/R11/R12", i), acc_rdata, VEC[i][15:0]);
      if (i == 4) begin
        acc_ptr_sel = 1'b1; #1;
        chk("R1 pointer readback", acc_rdata, 16'h0003);
        acc_ptr_sel = 1'b0; #1;
      end
    end
    chk("R11 ib_addr low", ib_addr[15:0], 16'h1234);
    chk("R11 ib_addr high", {8'd0, ib_addr[23:16]}, 16'h00AB);
    chk("R11 bus_mode", {13'd0, bus_mode}, 16'h0007);
    chk("R7 run outputs", {13'd0, rx_on, tx_on, stopped}, 16'h0006);

    // R3 R5 events
    pulse(2);
    chk("R5 rx flag", acc_rdata, 16'h04F0);
    chk("R5 irq high", {15'd0, irq}, 16'h0001);
    wr(1'b0, 16'h0040);
    chk("R3 write zero keeps", acc_rdata, 16'h04F0);
    wr(1'b0, 16'h0440);
    chk("R3 w1c", acc_rdata, 16'h0070);
    chk("R5 irq low", {15'd0, irq}, 16'h0000);

    // R4 error summary
    pulse(6);
    chk("R4 babble summary", acc_rdata, 16'hC0F0);
    wr(1'b0, 16'hC040);
    chk("R4 summary read-only", acc_rdata, 16'h0070);

    // R3 event beats clear
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_wdata = 16'h0240; ev[1] = 1'b1;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_wdata = '0; ev = '0;
    #1;
    chk("R3 event wins", acc_rdata, 16'h02F0);
    wr(1'b0, 16'h0240);
    chk("R3 cleared", acc_rdata, 16'h0070);

    // R9 R10 transmit demand
    wr(1'b0, 16'h0048);
    chk("R10 demand bit", acc_rdata, 16'h0078);
    chk("R9 demand pulse", {15'd0, tx_demand}, 16'h0001);
    step();
    chk("R10 demand self clear", acc_rdata, 16'h0070);
    chk("R9 demand ends", {15'd0, tx_demand}, 16'h0000);

    // R5 enable gating
    pulse(0);
    chk("R5 idone irq", {irq, 3'd0, acc_rdata[11:0]}, 16'h81F0);
    wr(1'b0, 16'h0000);
    chk("R5 masked", acc_rdata, 16'h01B0);
    chk("R5 irq masked", {15'd0, irq}, 16'h0000);

    // R6 halt
    wr(1'b0, 16'h0004);
    chk("R6 halt", acc_rdata, 16'h0004);
    chk("R6 run outputs", {13'd0, rx_on, tx_on, stopped}, 16'h0001);
    pulse(4);
    chk("R6 event ignored", acc_rdata, 16'h0004);
    wr(1'b0, 16'h0008);
    chk("R9 demand ignored", acc_rdata, 16'h0004);
    chk("R9 no pulse", {15'd0, tx_demand}, 16'h0000);

    // R8 init
    wr(1'b0, 16'h0001);
    chk("R8 init bit", acc_rdata, 16'h0001);
    chk("R8 init pulse", {15'd0, init_start}, 16'h0001);
    step();
    chk("R10 init self clear", acc_rdata, 16'h0000);
    chk("R8 pulse ends", {15'd0, init_start}, 16'h0000);
    pulse(0);
    chk("R8 init done", acc_rdata, 16'h0180);
    pulse(7);
    chk("R8 init fail", acc_rdata, 16'h8980);

    // R6 halt beats start
    wr(1'b0, 16'h0006);
    chk("R6 halt wins", acc_rdata, 16'h0004);
    chk("R6 rx off", {15'd0, rx_on}, 16'h0000);

    finish_run();
  end

endmodule